// File: doc/BRIEF.md
# Time-of-Day Clock with Step and Rate Trim

This block keeps a running time of day: a 48-bit seconds count and a 30-bit nanoseconds count. On every clock the nanoseconds advance by a fixed nominal amount. When they reach one billion they wrap and carry into the seconds. Software reaches the clock through a small register port. One set of shadow registers serves three purposes: it receives a snapshot of the live time, it holds a new time to be loaded, and it holds a signed nanosecond offset for an atomic step.

A rate trim adjusts the clock frequency. The block measures elapsed time in a chosen unit, picoseconds or nanoseconds. Each time the programmed interval has elapsed, that clock's increment is made one nanosecond longer or one nanosecond shorter. The direction bit selects which.

Top module: `tod_clock`

## Requirements
- R1: Reset clears the live time, the shadow registers and both trim registers, so the trim starts out disabled.
- R2: With no action and no trim correction, each clock adds NS_PER_CLK (default 4) to the nanoseconds. A result of 1,000,000,000 or more wraps by subtracting one billion and adds one to the 48-bit seconds, including the carry from the low seconds word into the high word.
- R3: Register map by address: 0 command, whose action is in bits [1:0]; 1 shadow seconds high, bits [15:0]; 2 shadow seconds low, bits [31:0]; 3 shadow nanoseconds, bits [29:0]; 4 trim interval, bits [29:0], with the unit in bit 30 (1 = nanoseconds, 0 = picoseconds); 5 trim config, bit 0 enable and bit 1 direction (1 = remove). Reads are combinational, and unused bits read as zero.
- R4: The command register always reads as 0 (idle). An action takes effect on the clock edge that writes it.
- R5: Action 1 (save) copies the live time held before the write edge into the shadow registers. The live time keeps advancing.
- R6: Action 2 (load) replaces the live time with the shadow time at the write edge. Normal advance resumes on the next edge.
- R7: On load, a shadow nanoseconds value in 0x3FFFFFF0..0x3FFFFFFF means a slightly negative time. The live time becomes the shadow seconds minus one, with nanoseconds equal to 999,999,984 plus the value's low 4 bits.
- R8: Action 3 (delta) adds the shadow nanoseconds, read as a signed 30-bit value, to the live nanoseconds together with that edge's normal increment. The shadow seconds are ignored. A negative result borrows one second and a result of one billion or more carries one second, both in the same edge. The offset's magnitude must stay below 500,000,000.
- R9: While the trim is enabled, elapsed time accumulates in the chosen unit from the last write to register 4 or 5. On each edge where the accumulated time reaches the interval, that edge's increment gains 1 ns (direction 0) or loses 1 ns (direction 1), and the remainder is kept.
- R10: Writing zero to the trim config stops all corrections, so the time advances at the nominal rate.
- R11: Writing action 0 (idle) leaves the live time and the shadow registers untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Combinational read data |
| tod_sec_o | output | 48 | Live seconds |
| tod_ns_o | output | 30 | Live nanoseconds |

## Verification
The assertions assume that software only loads nanosecond values below one billion or inside the negative band, and that every delta offset stays below half a second in magnitude. Under those conditions the live nanoseconds can never reach one billion, and a single carry or borrow is always enough. The stimulus loads only legal times and steps by offsets of at most 400,000,000 ns in either direction. It also issues at most one register write per cycle, as the port implies. Each trim scenario restarts the interval accumulator with a config write and then loads a known time. This fixes the edges on which corrections fall, so the expected count of corrections is exact.

// File: rtl/tod_pkg.sv
package tod_pkg;
    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,
        ACT_SAVE = 2'd1,
        ACT_LOAD = 2'd2,
        ACT_STEP = 2'd3
    } tod_act_e;

    localparam logic [2:0] REG_CMD      = 3'd0;
    localparam logic [2:0] REG_SEC_HI   = 3'd1;
    localparam logic [2:0] REG_SEC_LO   = 3'd2;
    localparam logic [2:0] REG_NSEC     = 3'd3;
    localparam logic [2:0] REG_TRIM_IVL = 3'd4;
    localparam logic [2:0] REG_TRIM_CFG = 3'd5;

    localparam int unsigned NS_PER_SEC    = 1000000000;
    localparam int unsigned PS_PER_NS     = 1000;
    localparam int unsigned NEG_BAND_BASE = 999999984;
endpackage

// File: rtl/tod_step_calc.sv
// Adds a signed amount to a time value and normalises it with one carry or borrow.
module tod_step_calc
    import tod_pkg::*;
#(
    parameter int SEC_W = 48,
    parameter int NS_W  = 30
) (
    input  logic [SEC_W-1:0]        sec_i,
    input  logic [NS_W-1:0]         ns_i,
    input  logic signed [NS_W+2:0]  add_i,
    output logic [SEC_W-1:0]        sec_o,
    output logic [NS_W-1:0]         ns_o
);
    localparam int SUM_W = NS_W + 3;
    localparam logic signed [SUM_W-1:0] ONE_SEC = SUM_W'(NS_PER_SEC);

    logic signed [SUM_W-1:0] sum;

    always_comb begin
        sum = $signed({3'b000, ns_i}) + add_i;
        if (sum < 0) begin
            ns_o  = NS_W'(sum + ONE_SEC);
            sec_o = sec_i - SEC_W'(1);
        end else if (sum >= ONE_SEC) begin
            ns_o  = NS_W'(sum - ONE_SEC);
            sec_o = sec_i + SEC_W'(1);
        end else begin
            ns_o  = NS_W'(sum);
            sec_o = sec_i;
        end
    end
endmodule

// File: rtl/tod_rate_trim.sv
// Elapsed-time accumulator that flags the edges on which a 1 ns correction applies.
module tod_rate_trim
    import tod_pkg::*;
#(
    parameter int IVL_W      = 30,
    parameter int NS_PER_CLK = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             unit_ns_i,
    input  logic             restart_i,
    input  logic [IVL_W-1:0] ivl_i,
    output logic             fire_o
);
    localparam int ACC_W = IVL_W + 2;
    localparam logic [ACC_W-1:0] STEP_NS = ACC_W'(NS_PER_CLK);
    localparam logic [ACC_W-1:0] STEP_PS = ACC_W'(NS_PER_CLK * PS_PER_NS);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } trim_st_t;

    trim_st_t st_d, st_q;
    logic [ACC_W-1:0] step_d, sum_d, rem_d, ivl_ext;

    always_comb begin
        st_d    = st_q;
        fire_o  = 1'b0;
        ivl_ext = ACC_W'(ivl_i);
        step_d  = unit_ns_i ? STEP_NS : STEP_PS;
        sum_d   = st_q.acc + step_d;
        rem_d   = sum_d - ivl_ext;
        if (restart_i || !en_i) begin
            st_d.acc = '0;
        end else if (sum_d >= ivl_ext) begin
            fire_o   = 1'b1;
            st_d.acc = (rem_d >= ivl_ext) ? '0 : rem_d;
        end else begin
            st_d.acc = sum_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tod_clock.sv
module tod_clock
    import tod_pkg::*;
#(
    parameter int SEC_HI_W   = 16,
    parameter int NS_W       = 30,
    parameter int NS_PER_CLK = 4,
    parameter int IVL_W      = 30
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [2:0]            wr_addr,
    input  logic [31:0]           wr_data,
    input  logic [2:0]            rd_addr,
    output logic [31:0]           rd_data,
    output logic [SEC_HI_W+31:0]  tod_sec_o,
    output logic [NS_W-1:0]       tod_ns_o
);
    localparam int SEC_W = SEC_HI_W + 32;
    localparam int SUM_W = NS_W + 3;
    localparam logic signed [SUM_W-1:0] NOM_INC = SUM_W'(NS_PER_CLK);
    localparam logic signed [SUM_W-1:0] ONE_NS  = SUM_W'(1);

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
        logic [SEC_W-1:0] shd_sec;
        logic [NS_W-1:0]  shd_ns;
        logic [IVL_W-1:0] ivl;
        logic             ivl_ns;
        logic             trim_en;
        logic             trim_dir;
    } tod_st_t;

    tod_st_t st_d, st_q;

    logic                    trim_fire;
    logic                    trim_restart;
    logic                    trim_en_w;
    logic [NS_W-1:0]         shd_ns_w;
    logic signed [SUM_W-1:0] inc_d;
    logic signed [SUM_W-1:0] step_add_d;
    logic [SEC_W-1:0]        tick_sec, step_sec;
    logic [NS_W-1:0]         tick_ns, step_ns;
    logic                    neg_band;
    logic [SEC_W-1:0]        load_sec;
    logic [NS_W-1:0]         load_ns;
    logic                    cmd_wr;
    tod_act_e                act;

    assign trim_restart = wr_en && (wr_addr == REG_TRIM_IVL || wr_addr == REG_TRIM_CFG);
    assign trim_en_w    = st_q.trim_en;
    assign shd_ns_w     = st_q.shd_ns;

    tod_rate_trim #(
        .IVL_W      (IVL_W),
        .NS_PER_CLK (NS_PER_CLK)
    ) u_trim (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (st_q.trim_en),
        .unit_ns_i (st_q.ivl_ns),
        .restart_i (trim_restart),
        .ivl_i     (st_q.ivl),
        .fire_o    (trim_fire)
    );

    always_comb begin
        inc_d = NOM_INC;
        if (trim_fire) inc_d = st_q.trim_dir ? (NOM_INC - ONE_NS) : (NOM_INC + ONE_NS);
        step_add_d = inc_d + $signed({{3{st_q.shd_ns[NS_W-1]}}, st_q.shd_ns});
    end

    tod_step_calc #(.SEC_W(SEC_W), .NS_W(NS_W)) u_tick (
        .sec_i (st_q.sec),
        .ns_i  (st_q.ns),
        .add_i (inc_d),
        .sec_o (tick_sec),
        .ns_o  (tick_ns)
    );

    tod_step_calc #(.SEC_W(SEC_W), .NS_W(NS_W)) u_step (
        .sec_i (st_q.sec),
        .ns_i  (st_q.ns),
        .add_i (step_add_d),
        .sec_o (step_sec),
        .ns_o  (step_ns)
    );

    // Slightly negative snapshot encoding: top bits all ones.
    always_comb begin
        neg_band = &st_q.shd_ns[NS_W-1:4];
        if (neg_band) begin
            load_sec = st_q.shd_sec - SEC_W'(1);
            load_ns  = NS_W'(NEG_BAND_BASE) + NS_W'(st_q.shd_ns[3:0]);
        end else begin
            load_sec = st_q.shd_sec;
            load_ns  = st_q.shd_ns;
        end
    end

    always_comb begin
        st_d    = st_q;
        st_d.sec = tick_sec;
        st_d.ns  = tick_ns;
        cmd_wr  = wr_en && (wr_addr == REG_CMD);
        act     = tod_act_e'(wr_data[1:0]);
        if (cmd_wr) begin
            unique case (act)
                ACT_SAVE: begin
                    st_d.shd_sec = st_q.sec;
                    st_d.shd_ns  = st_q.ns;
                end
                ACT_LOAD: begin
                    st_d.sec = load_sec;
                    st_d.ns  = load_ns;
                end
                ACT_STEP: begin
                    st_d.sec = step_sec;
                    st_d.ns  = step_ns;
                end
                default: ;
            endcase
        end else if (wr_en) begin
            unique case (wr_addr)
                REG_SEC_HI:   st_d.shd_sec[SEC_W-1:32] = wr_data[SEC_HI_W-1:0];
                REG_SEC_LO:   st_d.shd_sec[31:0]       = wr_data;
                REG_NSEC:     st_d.shd_ns              = wr_data[NS_W-1:0];
                REG_TRIM_IVL: begin
                    st_d.ivl    = wr_data[IVL_W-1:0];
                    st_d.ivl_ns = wr_data[IVL_W];
                end
                REG_TRIM_CFG: begin
                    st_d.trim_en  = wr_data[0];
                    st_d.trim_dir = wr_data[1];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (rd_addr)
            REG_SEC_HI:   rd_data = 32'(st_q.shd_sec[SEC_W-1:32]);
            REG_SEC_LO:   rd_data = st_q.shd_sec[31:0];
            REG_NSEC:     rd_data = 32'(st_q.shd_ns);
            REG_TRIM_IVL: rd_data = 32'({st_q.ivl_ns, st_q.ivl});
            REG_TRIM_CFG: rd_data = {30'd0, st_q.trim_dir, st_q.trim_en};
            default:      rd_data = 32'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tod_sec_o = st_q.sec;
    assign tod_ns_o  = st_q.ns;
endmodule

// File: rtl/tod_clock_chk.sv
module tod_clock_chk
    import tod_pkg::*;
#(
    parameter int SEC_W      = 48,
    parameter int NS_W       = 30,
    parameter int NS_PER_CLK = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [2:0]       wr_addr,
    input logic [1:0]       wr_act,
    input logic [2:0]       rd_addr,
    input logic [31:0]      rd_data,
    input logic [SEC_W-1:0] tod_sec_o,
    input logic [NS_W-1:0]  tod_ns_o,
    input logic             trim_fire,
    input logic             trim_en,
    input logic [NS_W-1:0]  shd_ns
);
    logic cmd_wr;
    assign cmd_wr = wr_en && (wr_addr == REG_CMD);

    // R2
    ns_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(tod_ns_o) < 32'(NS_PER_SEC));

    // R2
    nominal_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_wr && !trim_fire) |=>
            ((32'(tod_ns_o) == 32'($past(tod_ns_o)) + 32'(NS_PER_CLK)) && (tod_sec_o == $past(tod_sec_o)))
         || ((32'(tod_ns_o) + 32'(NS_PER_SEC) == 32'($past(tod_ns_o)) + 32'(NS_PER_CLK))
             && (tod_sec_o == $past(tod_sec_o) + SEC_W'(1))));

    // R4
    cmd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == REG_CMD) |-> (rd_data == 32'd0));

    // R5
    save_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && wr_act == 2'd1) |=> (shd_ns == $past(tod_ns_o)));

    // R10
    trim_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trim_en |-> !trim_fire);
endmodule

bind tod_clock tod_clock_chk #(
    .SEC_W      (SEC_HI_W + 32),
    .NS_W       (NS_W),
    .NS_PER_CLK (NS_PER_CLK)
) u_tod_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_act    (wr_data[1:0]),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .tod_sec_o (tod_sec_o),
    .tod_ns_o  (tod_ns_o),
    .trim_fire (trim_fire),
    .trim_en   (trim_en_w),
    .shd_ns    (shd_ns_w)
);

// File: tb/tb_tod_clock.sv
`timescale 1ns/1ps
module tb_tod_clock;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = 3'd0;
    logic [31:0] wr_data = 32'd0;
    logic [2:0]  rd_addr = 3'd0;
    logic [31:0] rd_data;
    logic [47:0] tod_sec_o;
    logic [29:0] tod_ns_o;

    always #2 clk = ~clk;

    tod_clock dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .tod_sec_o (tod_sec_o),
        .tod_ns_o  (tod_ns_o)
    );

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    int   checks = 0;
    int   failures = 0;
    logic rd_req = 1'b0;
    logic finished = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard once the read address has settled.
    always begin
        @(negedge clk);
        #1;
        if (rd_req && sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            check(it.tag, rd_data, it.exp);
            rd_req = 1'b0;
        end
    end

    task automatic expect_reg(input logic [2:0] a, input logic [31:0] e, input string tag);
        sb_item_t it;
        @(negedge clk);
        rd_addr = a;
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
        rd_req = 1'b1;
        wait (rd_req == 1'b0);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_time(input logic [31:0] hi, input logic [31:0] lo, input logic [31:0] ns);
        wr(3'd1, hi);
        wr(3'd2, lo);
        wr(3'd3, ns);
        wr(3'd0, 32'd2);
    endtask

    task automatic save_expect(input logic [31:0] hi, input logic [31:0] lo, input logic [31:0] ns,
                               input string tag);
        wr(3'd0, 32'd1);
        expect_reg(3'd1, hi, {tag, " sec_hi"});
        expect_reg(3'd2, lo, {tag, " sec_lo"});
        expect_reg(3'd3, ns, {tag, " nsec"});
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: live time held at zero in reset
        check("R1 live ns in reset", 32'(tod_ns_o), 32'd0);
        check("R1 live sec in reset", tod_sec_o[31:0], 32'd0);
        rst_n = 1'b1;
        expect_reg(3'd1, 32'd0, "R1 shadow sec_hi");
        expect_reg(3'd2, 32'd0, "R1 shadow sec_lo");
        expect_reg(3'd3, 32'd0, "R1 shadow nsec");
        expect_reg(3'd4, 32'd0, "R1 trim interval");
        expect_reg(3'd5, 32'd0, "R1 trim config");

        // R6 R5: load then save on the next write slot (one extra tick)
        load_time(32'h12, 32'h3456789A, 32'd100);
        save_expect(32'h12, 32'h3456789A, 32'd104, "R6 R5 load/save");

        // R2: wrap of ns with carry from low to high seconds word
        load_time(32'h0, 32'hFFFF_FFFF, 32'd999999998);
        save_expect(32'h1, 32'h0, 32'd2, "R2 wrap carry");

        // R2: ten nominal ticks
        load_time(32'h0, 32'd7, 32'd500);
        idle(9);
        save_expect(32'h0, 32'd7, 32'd540, "R2 nominal rate");

        // R11 R4: idle command changes nothing, command reads zero
        load_time(32'h0, 32'd7, 32'd500);
        wr(3'd0, 32'd0);
        save_expect(32'h0, 32'd7, 32'd512, "R11 idle action");
        expect_reg(3'd0, 32'd0, "R4 command reads idle");

        // R8: positive step
        load_time(32'h0, 32'd5, 32'd1000);
        wr(3'd3, 32'd500);
        wr(3'd0, 32'd3);
        save_expect(32'h0, 32'd5, 32'd1520, "R8 step positive");

        // R8: negative step with borrow
        load_time(32'h0, 32'd5, 32'd1000);
        wr(3'd3, 32'h3FFF_F830);
        wr(3'd0, 32'd3);
        save_expect(32'h0, 32'd4, 32'd999999020, "R8 step borrow");

        // R8: positive step with carry
        load_time(32'h0, 32'd5, 32'd999000000);
        wr(3'd3, 32'd400000000);
        wr(3'd0, 32'd3);
        save_expect(32'h0, 32'd6, 32'd399000020, "R8 step carry");

        // R7: negative band on load
        load_time(32'h0, 32'd10, 32'h3FFF_FFF5);
        save_expect(32'h0, 32'd9, 32'd999999993, "R7 negative band");

        // R9: ns unit, interval 20, add direction
        wr(3'd1, 32'h0); wr(3'd2, 32'd3); wr(3'd3, 32'd0);
        wr(3'd4, 32'h4000_0014);
        wr(3'd5, 32'd1);
        wr(3'd0, 32'd2);
        idle(9);
        save_expect(32'h0, 32'd3, 32'd42, "R9 trim faster");
        expect_reg(3'd4, 32'h4000_0014, "R3 trim interval readback");

        // R9: remove direction
        wr(3'd1, 32'h0); wr(3'd2, 32'd3); wr(3'd3, 32'd0);
        wr(3'd4, 32'h4000_0014);
        wr(3'd5, 32'd3);
        wr(3'd0, 32'd2);
        idle(9);
        save_expect(32'h0, 32'd3, 32'd38, "R9 trim slower");
        expect_reg(3'd5, 32'd3, "R3 trim config readback");

        // R9: picosecond unit, interval 10000 ps
        wr(3'd1, 32'h0); wr(3'd2, 32'd3); wr(3'd3, 32'd0);
        wr(3'd4, 32'd10000);
        wr(3'd5, 32'd1);
        wr(3'd0, 32'd2);
        idle(9);
        save_expect(32'h0, 32'd3, 32'd44, "R9 trim ps unit");

        // R10: config zero disables correction
        wr(3'd1, 32'h0); wr(3'd2, 32'd3); wr(3'd3, 32'd0);
        wr(3'd4, 32'h4000_0014);
        wr(3'd5, 32'd0);
        wr(3'd0, 32'd2);
        idle(9);
        save_expect(32'h0, 32'd3, 32'd40, "R10 trim disabled");

        idle(4);
        finish_run();
    end
endmodule